// File: doc/BRIEF.md
# Codec Bring-Up Command Sequencer

This block is a state machine that starts an audio codec over a time-division-multiplexed serial link. First it holds the codec reset pin low for a programmed number of clock cycles. Then it watches receive slot 0 for the codec-ready indication. Once the codec is ready, it issues a fixed list of control-register writes, one per frame, through the first three transmit slots.

Read-back checking is optional. When it is enabled, the sequencer requests each register back and compares the returned address and data against the list. Any difference raises a sticky mismatch flag, and the run still continues. The sequence always ends with a power cycle of the converters: a power-down write, a programmed gap, a power-up write and a warm-up delay. After that the done flag is raised.

A serial shifter outside this block turns the slot words into bits. It pulses `frame_tick` once each time a frame has been fully sent and received. The block changes its transmit words only in the cycle after a tick or after one of its timers expires.

Top module: `codec_boot_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are as follows. `codec_rst_n`, `done` and `mismatch` are 0. `tx_tag` is 0x8000. `tx_cmd_addr` is 0. `tx_cmd_data` is 0xFF80, which selects 16-bit slot mode. These words stay on the outputs until the first command is loaded.
- R2: After `rst_n` is released, `codec_rst_n` stays low for exactly `RST_HOLD` rising clock edges. It then goes high and stays high until the next reset.
- R3: No command is issued until the following has happened. A `frame_tick` must arrive while `rx_slot0` bit 15 is 1. After that, two more `frame_tick` pulses must arrive. The first write is loaded on the second of those ticks. Ticks that arrive while bit 15 is 0 change nothing.
- R4: A write frame uses tag 0xE000. Bit 15 is frame valid, bit 14 marks slot 1 valid and bit 13 marks slot 2 valid. `tx_cmd_addr` carries the register address and `tx_cmd_data` carries the value.
- R5: The table has 17 entries, numbered i = 0 to 16. Entry i has address 2+2i and data 0x0808 XOR (i*0x0101), truncated to 16 bits. The entries are sent in index order, one entry per frame, and each `frame_tick` advances to the next entry.
- R6: When `verify_en` is 1 at the end of the table, each entry is requested back in index order. A request uses tag 0xC000, an address word of (address | 0x8000), and a data word of 0.
- R7: The read-back sample is taken at the second `frame_tick` after the request's own tick. `mismatch` is set if `rx_slot3[14:0]` differs from the address or `rx_slot4` differs from the data. The flag stays set until reset, and the sequence goes on regardless.
- R8: In frames that carry no command, once the first command has been sent, the tag is 0x8000 and both command words are 0.
- R9: After the last table write, or after the last read-back sample, register 0x26 is written with 0x0300. Once that frame's tick has arrived, the sequencer waits `PWR_GAP` clock edges and then loads a write of 0x0000 to register 0x26.
- R10: `done` rises on the `WARM_CYC`-th clock edge after the tick that ends the power-up write. It stays high until reset.
- R11: When `verify_en` is 0, the power-down write comes in the frame right after the last table write, with no read requests in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse at the end of every frame |
| verify_en | input | 1 | Request read-back checking of the table |
| rx_slot0 | input | 16 | Receive slot 0; bit 15 is codec ready |
| rx_slot3 | input | 16 | Receive slot 3, returned register address |
| rx_slot4 | input | 16 | Receive slot 4, returned register data |
| tx_tag | output | 16 | Transmit slot 0, tag word |
| tx_cmd_addr | output | 16 | Transmit slot 1, command address |
| tx_cmd_data | output | 16 | Transmit slot 2, command data |
| codec_rst_n | output | 1 | Active-low codec reset pin |
| done | output | 1 | Bring-up finished |
| mismatch | output | 1 | Sticky read-back mismatch |

## Verification
The bench counts the exact number of edges in each timed window: the reset hold, the power gap and the warm-up. A counter that is off by one would release the pin, or load the power-up write, one edge early or late. The bench sends ready ticks at the start and idle ticks between read-back steps. A design that skipped the two settle frames, or sampled read-back one frame early, would show the wrong words or the wrong flag at those points. One entry gets a corrupted return value to show that the flag latches and the sequence still finishes. A second run with checking disabled looks for the power-down write directly after entry 16.

// File: rtl/codec_boot_seq.sv
module codec_boot_seq #(
  parameter int RST_HOLD = 65536,
  parameter int PWR_GAP  = 12288,
  parameter int WARM_CYC = 50000,
  parameter int NPAIR    = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_tick,
  input  logic        verify_en,
  input  logic [15:0] rx_slot0,
  input  logic [15:0] rx_slot3,
  input  logic [15:0] rx_slot4,
  output logic [15:0] tx_tag,
  output logic [15:0] tx_cmd_addr,
  output logic [15:0] tx_cmd_data,
  output logic        codec_rst_n,
  output logic        done,
  output logic        mismatch
);
  localparam int MAXC = (RST_HOLD > PWR_GAP) ? ((RST_HOLD > WARM_CYC) ? RST_HOLD : WARM_CYC)
                                             : ((PWR_GAP > WARM_CYC) ? PWR_GAP : WARM_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam int IW = $clog2(NPAIR);
  localparam logic [IW-1:0] LAST = IW'(NPAIR - 1);
  localparam logic [15:0] TAG_IDLE = 16'h8000, TAG_WR = 16'hE000, TAG_RD = 16'hC000;
  localparam logic [15:0] PWR_REG = 16'h0026, PWR_OFF = 16'h0300, SLOT16 = 16'hFF80;

  typedef enum logic [3:0] {
    S_RST, S_WRDY, S_SETL, S_WR, S_RREQ, S_RWT, S_PDN, S_GAP, S_PUP, S_WARM, S_DONE
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          fcnt;
  logic [15:0]   tag_q, a_q, d_q;
  logic [IW-1:0] nidx;

  function automatic logic [15:0] pair_addr(input logic [IW-1:0] i);
    return 16'(2 + 2 * int'(i));
  endfunction

  function automatic logic [15:0] pair_data(input logic [IW-1:0] i);
    logic [15:0] ix;
    ix = 16'(i);
    return 16'h0808 ^ (ix * 16'h0101);
  endfunction

  assign nidx        = idx + 1'b1;
  assign tx_tag      = tag_q;
  assign tx_cmd_addr = a_q;
  assign tx_cmd_data = d_q;
  assign codec_rst_n = (st != S_RST);
  assign done        = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_RST; cnt <= '0; idx <= '0; fcnt <= 1'b0; mismatch <= 1'b0;
      tag_q <= TAG_IDLE; a_q <= '0; d_q <= SLOT16;
    end else begin
      case (st)
        S_RST:
          if (cnt == CW'(RST_HOLD - 1)) begin st <= S_WRDY; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_WRDY:
          if (frame_tick && rx_slot0[15]) begin st <= S_SETL; fcnt <= 1'b0; end
        S_SETL:
          if (frame_tick) begin
            if (fcnt) begin
              st <= S_WR; idx <= '0;
              tag_q <= TAG_WR; a_q <= pair_addr('0); d_q <= pair_data('0);
            end else fcnt <= 1'b1;
          end
        S_WR:
          if (frame_tick) begin
            if (idx == LAST) begin
              idx <= '0;
              if (verify_en) begin
                st <= S_RREQ; tag_q <= TAG_RD; a_q <= pair_addr('0) | 16'h8000; d_q <= '0;
              end else begin
                st <= S_PDN; tag_q <= TAG_WR; a_q <= PWR_REG; d_q <= PWR_OFF;
              end
            end else begin
              idx <= nidx; a_q <= pair_addr(nidx); d_q <= pair_data(nidx);
            end
          end
        S_RREQ:
          if (frame_tick) begin
            st <= S_RWT; fcnt <= 1'b0; tag_q <= TAG_IDLE; a_q <= '0; d_q <= '0;
          end
        S_RWT:
          if (frame_tick) begin
            if (fcnt) begin
              if (rx_slot3[14:0] != pair_addr(idx)[14:0] || rx_slot4 != pair_data(idx))
                mismatch <= 1'b1;
              if (idx == LAST) begin
                st <= S_PDN; tag_q <= TAG_WR; a_q <= PWR_REG; d_q <= PWR_OFF;
              end else begin
                st <= S_RREQ; idx <= nidx;
                tag_q <= TAG_RD; a_q <= pair_addr(nidx) | 16'h8000; d_q <= '0;
              end
            end else fcnt <= 1'b1;
          end
        S_PDN:
          if (frame_tick) begin
            st <= S_GAP; cnt <= '0; tag_q <= TAG_IDLE; a_q <= '0; d_q <= '0;
          end
        S_GAP:
          if (cnt == CW'(PWR_GAP - 1)) begin
            st <= S_PUP; tag_q <= TAG_WR; a_q <= PWR_REG; d_q <= '0;
          end else cnt <= cnt + 1'b1;
        S_PUP:
          if (frame_tick) begin
            st <= S_WARM; cnt <= '0; tag_q <= TAG_IDLE; a_q <= '0; d_q <= '0;
          end
        S_WARM:
          if (cnt == CW'(WARM_CYC - 1)) st <= S_DONE;
          else cnt <= cnt + 1'b1;
        default: ;
      endcase
    end
  end

  // R1
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !codec_rst_n |-> (tx_tag == TAG_IDLE && tx_cmd_data == SLOT16));
  // R2
  pin_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    codec_rst_n |=> codec_rst_n);
  // R6
  read_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag == TAG_RD) |-> (tx_cmd_addr[15] && tx_cmd_data == 16'h0000));
  // R7
  mismatch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> mismatch);
  // R8
  tag_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tag == TAG_IDLE || tx_tag == TAG_WR || tx_tag == TAG_RD));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && tx_tag == TAG_IDLE));
endmodule

// File: tb/test_codec_boot_seq.sv
module test_codec_boot_seq;
  localparam int RST_HOLD = 64, PWR_GAP = 30, WARM_CYC = 100, NPAIR = 17;

  logic clk = 1'b0, rst_n = 1'b0, frame_tick = 1'b0, verify_en = 1'b0;
  logic [15:0] rx_slot0 = '0, rx_slot3 = '0, rx_slot4 = '0;
  logic [15:0] tx_tag, tx_cmd_addr, tx_cmd_data;
  logic codec_rst_n, done, mismatch;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  codec_boot_seq #(.RST_HOLD(RST_HOLD), .PWR_GAP(PWR_GAP), .WARM_CYC(WARM_CYC), .NPAIR(NPAIR))
  i_codec_boot_seq (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic logic [15:0] e_addr(int i); return 16'(2 + 2 * i); endfunction
  function automatic logic [15:0] e_data(int i); return 16'h0808 ^ 16'(i * 16'h0101); endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_words(input string req, input logic [15:0] t, a, d);
    chk(req, {16'h0, tx_tag, tx_cmd_addr, tx_cmd_data}, {16'h0, t, a, d});
  endtask

  task automatic frame(input logic [15:0] s0, s3, s4);
    @(negedge clk);
    rx_slot0 = s0; rx_slot3 = s3; rx_slot4 = s4; frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic t_reset_hold(input logic ven);
    int n;
    rst_n = 1'b0; verify_en = ven;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {tx_tag, tx_cmd_addr, tx_cmd_data, 13'h0, codec_rst_n, done, mismatch},
        {16'h8000, 16'h0000, 16'hFF80, 16'h0});
    rst_n = 1'b1;
    n = 0;
    while (!codec_rst_n) begin @(posedge clk); #1; n++; end
    chk("R2 reset hold edges", 64'(n), 64'(RST_HOLD));
  endtask

  task automatic t_ready_wait;
    repeat (3) frame(16'h0000, 16'h0, 16'h0);
    chk_words("R3 no command before ready", 16'h8000, 16'h0000, 16'hFF80);
    frame(16'h8000, 16'h0, 16'h0);
    frame(16'h8000, 16'h0, 16'h0);
    chk_words("R3 still waiting after one settle frame", 16'h8000, 16'h0000, 16'hFF80);
    frame(16'h8000, 16'h0, 16'h0);
    chk_words("R4 first write after two settle frames", 16'hE000, e_addr(0), e_data(0));
  endtask

  task automatic t_writes;
    for (int i = 1; i < NPAIR; i++) begin
      frame(16'h8000, 16'h0, 16'h0);
      chk_words("R5 table entry", 16'hE000, e_addr(i), e_data(i));
    end
  endtask

  task automatic t_readback(input int bad);
    chk_words("R6 first read request", 16'hC000, e_addr(0) | 16'h8000, 16'h0);
    for (int i = 0; i < NPAIR; i++) begin
      frame(16'h8000, 16'h0, 16'h0);
      chk_words("R8 idle after request", 16'h8000, 16'h0, 16'h0);
      frame(16'h8000, 16'h0, 16'h0);
      chk("R7 no early flag", 64'(mismatch), 64'(i > bad));
      frame(16'h8000, e_addr(i), (i == bad) ? e_data(i) ^ 16'h0001 : e_data(i));
      chk("R7 mismatch flag", 64'(mismatch), 64'(i >= bad));
      if (i < NPAIR - 1)
        chk_words("R6 next read request", 16'hC000, e_addr(i + 1) | 16'h8000, 16'h0);
    end
  endtask

  task automatic t_power;
    int n;
    chk_words("R9 power-down write", 16'hE000, 16'h0026, 16'h0300);
    frame(16'h8000, 16'h0, 16'h0);
    chk_words("R8 idle in gap", 16'h8000, 16'h0, 16'h0);
    n = 0;
    while (tx_tag != 16'hE000) begin @(posedge clk); #1; n++; end
    chk("R9 gap edges", 64'(n), 64'(PWR_GAP));
    chk_words("R9 power-up write", 16'hE000, 16'h0026, 16'h0000);
    frame(16'h8000, 16'h0, 16'h0);
    chk("R10 done low at warm-up start", 64'(done), 64'd0);
    n = 0;
    while (!done) begin @(posedge clk); #1; n++; end
    chk("R10 warm-up edges", 64'(n), 64'(WARM_CYC));
    repeat (3) frame(16'h8000, 16'h0, 16'h0);
    chk("R10 done stays high", 64'(done), 64'd1);
  endtask

  task automatic t_no_verify;
    t_reset_hold(1'b0);
    t_ready_wait;
    t_writes;
    frame(16'h8000, 16'h0, 16'h0);
    chk_words("R11 power-down right after table", 16'hE000, 16'h0026, 16'h0300);
    chk("R11 no mismatch", 64'(mismatch), 64'd0);
  endtask

  initial begin
    t_reset_hold(1'b1);
    t_ready_wait;
    t_writes;
    frame(16'h8000, 16'h0, 16'h0);
    t_readback(5);
    t_power;
    t_no_verify;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule